// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a small, fully associative translation buffer. Each of its entries describes a pair of neighbouring virtual pages, one even and one odd. The two pages share a tag, an address-space identifier and a page-size mask. Each page has its own physical frame base and its own attribute bits. A lookup presents a virtual address, the access kind and the current address-space identifier. One clock later the block returns a result code, the translated physical address and the read and write grants.

Entries are loaded through an indexed write port, one entry per cycle. The page size of an entry is set by a mask of extra offset bits. A mask of zero gives 4 KB pages, so each pair covers 8 KB. When a lookup hits, the attribute bits of the selected page are checked in a fixed priority order. When several entries hit at once, the block reports the lowest-indexed one and raises a separate flag for the multiple hit.

Top module: `tlb_pair_lookup`

## Requirements
- R1: An entry hits only when all of these hold: it has been written since reset; its hardware-invalidate bit is clear; its global bit is set or its stored address-space identifier equals `curAsid`; and the address bits above its effective mask equal its stored page-pair tag.
- R2: Within a hit entry, the highest bit of the effective mask selects the page. A 0 in that address bit selects the even page and a 1 selects the odd page.
- R3: The effective mask is the entry's programmed mask ORed with the low 13 address bits, so the smallest page is 4 KB. With a programmed mask of zero, address bit 12 selects the page.
- R4: The attribute fields are 4 bits: bit 3 valid, bit 2 dirty, bit 1 read-inhibit, bit 0 execute-inhibit. The access kind is 0 for a fetch, 1 for a load and 2 for a store. After a hit, the checks on the selected page run in this order:
  - valid clear gives INVALID (code 2);
  - a fetch with execute-inhibit set gives XI (code 5);
  - a load with read-inhibit set gives RI (code 4);
  - a store with dirty clear gives DIRTY (code 3);
  - otherwise the result is MATCH (code 0).
- R5: On MATCH, `respPaddr` equals the selected page's frame base ORed with the virtual address bits below the selected bit of the effective mask.
- R6: On MATCH, read is always granted and write is granted exactly when the selected page's dirty bit is set. On any other result, both grants are 0 and `respPaddr` is 0.
- R7: When no entry hits, the result is NOMATCH (code 1). Reset leaves every entry unused.
- R8: When several entries hit, the lowest index supplies the result and `respMultiHit` is 1. With exactly one hit, or none, `respMultiHit` is 0.
- R9: The result appears with `respValid` high on the cycle after `lookupValid`, and `respValid` is low otherwise. A write issued on the same cycle as a lookup does not affect that lookup, only later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Start a lookup this cycle |
| vaddr | input | VA_W | Virtual address to translate |
| accessType | input | 2 | 0 fetch, 1 load, 2 store |
| curAsid | input | ASID_W | Current address-space identifier |
| wrEn | input | 1 | Load an entry this cycle |
| wrIndex | input | $clog2(NUM_ENTRIES) | Entry slot to load |
| wrVpn | input | VA_W | Page-pair tag (bits above the mask are compared) |
| wrMask | input | VA_W | Extra page-size mask bits above bit 12 |
| wrAsid | input | ASID_W | Entry address-space identifier |
| wrGlobal | input | 1 | Entry matches any identifier |
| wrHwInval | input | 1 | Entry is excluded from matching |
| wrPfnEven | input | PA_W | Frame base of the even page |
| wrPfnOdd | input | PA_W | Frame base of the odd page |
| wrAttrEven | input | 4 | Even page attributes {valid, dirty, read-inhibit, execute-inhibit} |
| wrAttrOdd | input | 4 | Odd page attributes, same layout |
| respValid | output | 1 | Result registers hold a new result |
| respCode | output | 3 | Result code |
| respPaddr | output | PA_W | Physical address on MATCH, else 0 |
| respRead | output | 1 | Read granted |
| respWrite | output | 1 | Write granted |
| respMultiHit | output | 1 | More than one entry hit |

## Verification
The assertions assume that every programmed mask is a contiguous run of ones starting at bit 13, and that the access kind is never 3. The stimulus only writes masks formed as a run of 0 to 4 ones shifted up to bit 13, and only drives access kinds 0 to 2. The offset assertion assumes frame bases are aligned to the page size. Random frame bases are therefore cleared below the selected mask bit before they are written. Random tags are drawn from a pool of eight values, and identifiers from a pool of three. This makes multiple hits, identifier mismatches and global entries frequent without any targeted setup.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3,
    RES_RI      = 3'd4,
    RES_XI      = 3'd5
  } tlbResult_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } tlbAccess_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic readInh;
    logic execInh;
  } pageAttr_t;

  typedef struct packed {
    logic capture;
    logic grantRead;
    logic grantWrite;
    logic passAddr;
  } ctrlStrobe_t;

endpackage

// File: rtl/tlb_pair_ctrl.sv
module tlb_pair_ctrl
  import tlb_pair_pkg::*;
(
  input  logic        lookupValid,
  input  logic        anyHit,
  input  pageAttr_t   selAttr,
  input  logic [1:0]  accessType,
  output ctrlStrobe_t strobe,
  output tlbResult_e  resCode
);

  // Fixed-priority attribute checks on the chosen page half.
  always_comb begin
    strobe  = '0;
    resCode = RES_NOMATCH;
    if (lookupValid) begin
      strobe.capture = 1'b1;
      if (!anyHit) begin
        resCode = RES_NOMATCH;
      end else if (!selAttr.valid) begin
        resCode = RES_INVALID;
      end else if (accessType == ACC_FETCH && selAttr.execInh) begin
        resCode = RES_XI;
      end else if (accessType == ACC_LOAD && selAttr.readInh) begin
        resCode = RES_RI;
      end else if (accessType == ACC_STORE && !selAttr.dirty) begin
        resCode = RES_DIRTY;
      end else begin
        resCode           = RES_MATCH;
        strobe.grantRead  = 1'b1;
        strobe.grantWrite = selAttr.dirty;
        strobe.passAddr   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_pair_datapath.sv
module tlb_pair_datapath
  import tlb_pair_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int ASID_W      = 8,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lookupValid,
  input  logic [VA_W-1:0]                vaddr,
  input  logic [ASID_W-1:0]              curAsid,
  input  logic                           wrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wrIndex,
  input  logic [VA_W-1:0]                wrVpn,
  input  logic [VA_W-1:0]                wrMask,
  input  logic [ASID_W-1:0]              wrAsid,
  input  logic                           wrGlobal,
  input  logic                           wrHwInval,
  input  logic [PA_W-1:0]                wrPfnEven,
  input  logic [PA_W-1:0]                wrPfnOdd,
  input  pageAttr_t                      wrAttrEven,
  input  pageAttr_t                      wrAttrOdd,
  input  ctrlStrobe_t                    strobe,
  input  tlbResult_e                     resCode,
  output logic                           anyHit,
  output pageAttr_t                      selAttr,
  output logic                           respValid,
  output tlbResult_e                     respCode,
  output logic [PA_W-1:0]                respPaddr,
  output logic                           respRead,
  output logic                           respWrite,
  output logic                           respMultiHit
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [VA_W-1:0] MIN_MASK = VA_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

  logic [VA_W-1:0]   entVpn   [NUM_ENTRIES];
  logic [VA_W-1:0]   entMask  [NUM_ENTRIES];
  logic [ASID_W-1:0] entAsid  [NUM_ENTRIES];
  logic [PA_W-1:0]   entPfnE  [NUM_ENTRIES];
  logic [PA_W-1:0]   entPfnO  [NUM_ENTRIES];
  pageAttr_t         entAttrE [NUM_ENTRIES];
  pageAttr_t         entAttrO [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entGlobal;
  logic [NUM_ENTRIES-1:0] entHwInval;
  logic [NUM_ENTRIES-1:0] entUsed;

  logic [VA_W-1:0]        effMask [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] oddVec;

  // Entry storage: only the in-use flags need a reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entUsed <= '0;
    end else if (wrEn) begin
      entUsed[wrIndex] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      entVpn[wrIndex]     <= wrVpn;
      entMask[wrIndex]    <= wrMask;
      entAsid[wrIndex]    <= wrAsid;
      entGlobal[wrIndex]  <= wrGlobal;
      entHwInval[wrIndex] <= wrHwInval;
      entPfnE[wrIndex]    <= wrPfnEven;
      entPfnO[wrIndex]    <= wrPfnOdd;
      entAttrE[wrIndex]   <= wrAttrEven;
      entAttrO[wrIndex]   <= wrAttrOdd;
    end
  end

  // One comparator slice per entry.
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_match
    logic asidOk;
    logic tagOk;
    assign effMask[gi] = entMask[gi] | MIN_MASK;
    assign asidOk      = entGlobal[gi] || (entAsid[gi] == curAsid);
    assign tagOk       = ((vaddr ^ entVpn[gi]) & ~effMask[gi]) == '0;
    assign hitVec[gi]  = entUsed[gi] && !entHwInval[gi] && asidOk && tagOk;
    assign oddVec[gi]  = |(vaddr & effMask[gi] & ~(effMask[gi] >> 1));
  end

  logic [IDX_W-1:0] selIdx;
  logic [CNT_W-1:0] hitCount;
  logic             selOdd;
  logic             multiHit;
  logic [PA_W-1:0]  selPaddr;

  // Lowest index wins; count hits for the multi-hit flag.
  always_comb begin
    selIdx   = '0;
    hitCount = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selIdx   = IDX_W'(i);
        hitCount = hitCount + CNT_W'(1);
      end
    end
  end

  assign anyHit   = |hitVec;
  assign multiHit = hitCount > CNT_W'(1);
  assign selOdd   = oddVec[selIdx];
  assign selAttr  = selOdd ? entAttrO[selIdx] : entAttrE[selIdx];
  assign selPaddr = (selOdd ? entPfnO[selIdx] : entPfnE[selIdx]) |
                    PA_W'(vaddr & (effMask[selIdx] >> 1));

  // Result registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respCode     <= RES_NOMATCH;
      respPaddr    <= '0;
      respRead     <= 1'b0;
      respWrite    <= 1'b0;
      respMultiHit <= 1'b0;
    end else begin
      respValid <= strobe.capture;
      if (strobe.capture) begin
        respCode     <= resCode;
        respPaddr    <= strobe.passAddr ? selPaddr : '0;
        respRead     <= strobe.grantRead;
        respWrite    <= strobe.grantWrite;
        respMultiHit <= multiHit;
      end
    end
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid); // R9
  AST_EMPTY_GIVES_NOMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && entUsed == '0) |=> respCode == RES_NOMATCH); // R7
  AST_PA_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == RES_MATCH) |->
      ((respPaddr[PAGE_SHIFT-1:0] & $past(vaddr[PAGE_SHIFT-1:0])) ==
        $past(vaddr[PAGE_SHIFT-1:0]))); // R5
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respMultiHit) |-> respCode != RES_NOMATCH); // R8

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int ASID_W      = 8,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lookupValid,
  input  logic [VA_W-1:0]                vaddr,
  input  logic [1:0]                     accessType,
  input  logic [ASID_W-1:0]              curAsid,
  input  logic                           wrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wrIndex,
  input  logic [VA_W-1:0]                wrVpn,
  input  logic [VA_W-1:0]                wrMask,
  input  logic [ASID_W-1:0]              wrAsid,
  input  logic                           wrGlobal,
  input  logic                           wrHwInval,
  input  logic [PA_W-1:0]                wrPfnEven,
  input  logic [PA_W-1:0]                wrPfnOdd,
  input  logic [3:0]                     wrAttrEven,
  input  logic [3:0]                     wrAttrOdd,
  output logic                           respValid,
  output logic [2:0]                     respCode,
  output logic [PA_W-1:0]                respPaddr,
  output logic                           respRead,
  output logic                           respWrite,
  output logic                           respMultiHit
);

  ctrlStrobe_t strobe;
  tlbResult_e  resCode;
  tlbResult_e  respCodeE;
  pageAttr_t   selAttr;
  logic        anyHit;

  tlb_pair_ctrl u_ctrl (
    .lookupValid (lookupValid),
    .anyHit      (anyHit),
    .selAttr     (selAttr),
    .accessType  (accessType),
    .strobe      (strobe),
    .resCode     (resCode)
  );

  tlb_pair_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .VA_W        (VA_W),
    .PA_W        (PA_W),
    .ASID_W      (ASID_W),
    .PAGE_SHIFT  (PAGE_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .lookupValid  (lookupValid),
    .vaddr        (vaddr),
    .curAsid      (curAsid),
    .wrEn         (wrEn),
    .wrIndex      (wrIndex),
    .wrVpn        (wrVpn),
    .wrMask       (wrMask),
    .wrAsid       (wrAsid),
    .wrGlobal     (wrGlobal),
    .wrHwInval    (wrHwInval),
    .wrPfnEven    (wrPfnEven),
    .wrPfnOdd     (wrPfnOdd),
    .wrAttrEven   (pageAttr_t'(wrAttrEven)),
    .wrAttrOdd    (pageAttr_t'(wrAttrOdd)),
    .strobe       (strobe),
    .resCode      (resCode),
    .anyHit       (anyHit),
    .selAttr      (selAttr),
    .respValid    (respValid),
    .respCode     (respCodeE),
    .respPaddr    (respPaddr),
    .respRead     (respRead),
    .respWrite    (respWrite),
    .respMultiHit (respMultiHit)
  );

  assign respCode = respCodeE;

  AST_XI_ONLY_ON_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == RES_XI) |-> $past(accessType) == ACC_FETCH); // R4
  AST_RI_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == RES_RI) |-> $past(accessType) == ACC_LOAD); // R4
  AST_DIRTY_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == RES_DIRTY) |-> $past(accessType) == ACC_STORE); // R4
  AST_WRITE_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respWrite) |-> (respCode == RES_MATCH && respRead)); // R6
  AST_READ_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == RES_MATCH) |-> respRead); // R6

endmodule

// File: tb/tlb_pair_lookup_tb.sv
module tlb_pair_lookup_tb_top;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  accessType = '0;
  logic [7:0]  curAsid = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIndex = '0;
  logic [31:0] wrVpn = '0, wrMask = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0, wrHwInval = 1'b0;
  logic [31:0] wrPfnEven = '0, wrPfnOdd = '0;
  logic [3:0]  wrAttrEven = '0, wrAttrOdd = '0;
  logic        respValid;
  logic [2:0]  respCode;
  logic [31:0] respPaddr;
  logic        respRead, respWrite, respMultiHit;

  always #2 clk = ~clk;

  tlb_pair_lookup dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .vaddr(vaddr),
    .accessType(accessType), .curAsid(curAsid), .wrEn(wrEn), .wrIndex(wrIndex),
    .wrVpn(wrVpn), .wrMask(wrMask), .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrHwInval(wrHwInval), .wrPfnEven(wrPfnEven), .wrPfnOdd(wrPfnOdd),
    .wrAttrEven(wrAttrEven), .wrAttrOdd(wrAttrOdd), .respValid(respValid),
    .respCode(respCode), .respPaddr(respPaddr), .respRead(respRead),
    .respWrite(respWrite), .respMultiHit(respMultiHit)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Shadow copy of what has been written.
  logic [31:0] sVpn [N], sMask [N], sPfnE [N], sPfnO [N];
  logic [7:0]  sAsid [N];
  logic [3:0]  sAttrE [N], sAttrO [N];
  logic        sG [N], sHi [N], sUsed [N];

  typedef struct packed {
    logic [2:0]  code;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    logic        mh;
  } expect_t;

  function automatic expect_t model(logic [31:0] va, logic [1:0] acc, logic [7:0] asid);
    expect_t e;
    int cnt = 0;
    int idx = 0;
    logic [31:0] eff;
    logic [3:0] at;
    logic odd;
    e = '0;
    for (int i = 0; i < N; i++) begin
      eff = sMask[i] | 32'h1FFF;
      if (sUsed[i] && !sHi[i] && (sG[i] || sAsid[i] == asid) &&
          ((va & ~eff) == (sVpn[i] & ~eff))) begin
        if (cnt == 0) idx = i;
        cnt++;
      end
    end
    if (cnt == 0) begin
      e.code = 3'd1;
      return e;
    end
    e.mh = (cnt > 1);
    eff = sMask[idx] | 32'h1FFF;
    odd = |(va & eff & ~(eff >> 1));
    at  = odd ? sAttrO[idx] : sAttrE[idx];
    if (!at[3])                   e.code = 3'd2;
    else if (acc == 2'd0 && at[0]) e.code = 3'd5;
    else if (acc == 2'd1 && at[1]) e.code = 3'd4;
    else if (acc == 2'd2 && !at[2]) e.code = 3'd3;
    else begin
      e.code = 3'd0;
      e.pa   = (odd ? sPfnO[idx] : sPfnE[idx]) | (va & (eff >> 1));
      e.rd   = 1'b1;
      e.wr   = at[2];
    end
    return e;
  endfunction

  task automatic stageWrite(int idx, logic [31:0] vpn, logic [31:0] mask, logic [7:0] asid,
                            logic g, logic hi, logic [31:0] pe, logic [31:0] po,
                            logic [3:0] ae, logic [3:0] ao);
    wrEn = 1'b1; wrIndex = 4'(idx); wrVpn = vpn; wrMask = mask; wrAsid = asid;
    wrGlobal = g; wrHwInval = hi; wrPfnEven = pe; wrPfnOdd = po;
    wrAttrEven = ae; wrAttrOdd = ao;
  endtask

  task automatic stageLookup(logic [31:0] va, logic [1:0] acc, logic [7:0] asid);
    lookupValid = 1'b1; vaddr = va; accessType = acc; curAsid = asid;
  endtask

  // Clock one cycle, then check the response at the next falling edge.
  task automatic tick(string tag);
    expect_t e;
    bit didLook = lookupValid;
    e = model(vaddr, accessType, curAsid);
    @(posedge clk);
    if (wrEn) begin
      sVpn[wrIndex] = wrVpn; sMask[wrIndex] = wrMask; sAsid[wrIndex] = wrAsid;
      sG[wrIndex] = wrGlobal; sHi[wrIndex] = wrHwInval; sPfnE[wrIndex] = wrPfnEven;
      sPfnO[wrIndex] = wrPfnOdd; sAttrE[wrIndex] = wrAttrEven; sAttrO[wrIndex] = wrAttrOdd;
      sUsed[wrIndex] = 1'b1;
    end
    @(negedge clk);
    wrEn = 1'b0;
    lookupValid = 1'b0;
    checks++;
    if (didLook) begin
      if (respValid !== 1'b1 || respCode !== e.code || respPaddr !== e.pa ||
          respRead !== e.rd || respWrite !== e.wr || respMultiHit !== e.mh) begin
        errors++;
        $display("FAIL %s: got v=%b code=%0d pa=%h r=%b w=%b mh=%b exp v=1 code=%0d pa=%h r=%b w=%b mh=%b",
                 tag, respValid, respCode, respPaddr, respRead, respWrite, respMultiHit,
                 e.code, e.pa, e.rd, e.wr, e.mh);
      end
    end else if (respValid !== 1'b0) begin
      errors++;
      $display("FAIL %s: respValid got %b exp 0", tag, respValid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    for (int i = 0; i < N; i++) begin
      sUsed[i] = 1'b0; sVpn[i] = '0; sMask[i] = '0; sPfnE[i] = '0; sPfnO[i] = '0;
      sAsid[i] = '0; sAttrE[i] = '0; sAttrO[i] = '0; sG[i] = 1'b0; sHi[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state: no response without a lookup (R9), empty buffer misses (R7)
    tick("R9 reset idle");
    stageLookup(32'h0040_0123, 2'd1, 8'd5); tick("R7 empty after reset");

    // Small pages: bit 12 picks the half (R2, R3, R5)
    stageWrite(0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h1000_0000, 32'h2000_0000, 4'b1100, 4'b1100);
    tick("R9 write only");
    stageLookup(32'h0040_0123, 2'd1, 8'd5); tick("R2 R5 even page");
    stageLookup(32'h0040_1ABC, 2'd2, 8'd5); tick("R3 R6 odd page store");
    stageLookup(32'h0040_0123, 2'd1, 8'd6); tick("R1 asid mismatch");

    // Global 16 KB pages: bit 14 picks the half (R1, R2, R5)
    stageWrite(1, 32'h0080_0000, 32'h0000_6000, 8'd9, 1'b1, 1'b0, 32'h3000_0000, 32'h4000_8000, 4'b1100, 4'b1100);
    tick("R9 write only");
    stageLookup(32'h0080_4567, 2'd0, 8'd99); tick("R1 R2 global odd 16K");
    stageLookup(32'h0080_2567, 2'd1, 8'd0); tick("R5 global even 16K");

    // Attribute priority (R4, R6)
    stageWrite(2, 32'h0100_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h5000_0000, 32'h5100_0000, 4'b0111, 4'b1011);
    tick("R9 write only");
    stageLookup(32'h0100_0010, 2'd0, 8'd5); tick("R4 invalid beats xi");
    stageLookup(32'h0100_1010, 2'd0, 8'd5); tick("R4 xi on fetch");
    stageLookup(32'h0100_1010, 2'd1, 8'd5); tick("R4 ri on load");
    stageLookup(32'h0100_1010, 2'd2, 8'd5); tick("R4 dirty on store");
    stageWrite(3, 32'h0200_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h6000_0000, 32'h6100_0000, 4'b1000, 4'b1000);
    tick("R9 write only");
    stageLookup(32'h0200_1FFC, 2'd1, 8'd5); tick("R6 clean page read only");
    stageLookup(32'h0200_1FFC, 2'd0, 8'd5); tick("R6 clean page fetch");

    // Hardware-invalidate bit excludes the entry (R1)
    stageWrite(4, 32'h0300_0000, 32'h0, 8'd5, 1'b1, 1'b1, 32'h7000_0000, 32'h7100_0000, 4'b1100, 4'b1100);
    tick("R9 write only");
    stageLookup(32'h0300_0004, 2'd1, 8'd5); tick("R1 hw invalidate");

    // Multiple hits: lowest index wins and the flag is raised (R8)
    stageWrite(7, 32'h0500_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h8800_0000, 32'h8900_0000, 4'b1100, 4'b1100);
    tick("R9 write only");
    stageWrite(5, 32'h0500_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h8000_0000, 32'h8100_0000, 4'b1100, 4'b1100);
    tick("R9 write only");
    stageLookup(32'h0500_0444, 2'd1, 8'd5); tick("R8 multi hit lowest index");

    // Write and lookup in the same cycle: the lookup sees the old contents (R9)
    stageWrite(6, 32'h0600_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h9000_0000, 32'h9100_0000, 4'b1100, 4'b1100);
    stageLookup(32'h0600_0020, 2'd1, 8'd5); tick("R9 same cycle write");
    stageLookup(32'h0600_0020, 2'd1, 8'd5); tick("R9 write visible next");

    // Constrained random mix
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(3) == 0) begin
        logic [31:0] mask, half;
        int k = $urandom_range(4);
        mask = ((32'd1 << k) - 32'd1) << 13;
        half = (mask | 32'h1FFF) >> 1;
        stageWrite($urandom_range(N - 1), 32'($urandom_range(7)) << 22, mask,
                   8'($urandom_range(3, 1)), ($urandom_range(3) == 0),
                   ($urandom_range(7) == 0), $urandom & ~half, $urandom & ~half,
                   4'($urandom), 4'($urandom));
      end
      if ($urandom_range(4) != 0) begin
        stageLookup((32'($urandom_range(7)) << 22) | ($urandom & 32'h0003_FFFF),
                    2'($urandom_range(2)), 8'($urandom_range(3, 1)));
      end
      tick("R1,R2,R4,R5,R6,R8 random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule